// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block drives the external memory bus of a small 8-bit controller core. The core hands it one request at a time. A request is either a fetch from code space or an access to external data space. A data access uses a full 16-bit pointer, or a paged 8-bit offset whose upper address byte comes from a page register that software writes. The block puts the address on a 16-bit bus and then pulses exactly one active-low strobe. A code ROM and a data RAM can therefore occupy the same address range, because each device answers only to its own strobe.

Every access takes the same fixed sequence. One setup cycle drives the address with all strobes high. A parameterised number of cycles follows with the chosen strobe low. A final hold cycle raises the strobe again and keeps the address unchanged. The read data is captured on the edge that ends the strobe, and it appears together with a one-cycle done pulse in the hold cycle. Requests for internal memory are passed over, so the external bus does not move for them.

Top module: `xbus_strobe_ctrl`

## Requirements
- R1: During and after reset, and whenever the block is idle, `code_en_n`, `rd_n` and `wr_n` are high, `bus_dout_oe` is 0, `done` is 0 and `ready` is 1.
- R2: A request with `req_kind`=2'b01 (code space) drives only `code_en_n` low during the strobe phase. `rd_n` and `wr_n` stay high, and `req_write` is ignored.
- R3: A request with `req_kind`=2'b10 (pointer access) puts all 16 bits of `req_addr` on `bus_addr`. If it is a read (`req_write`=0), it drives only `rd_n` low.
- R4: A data write (`req_kind` 2'b10 or 2'b11 with `req_write`=1) drives only `wr_n` low. `bus_dout_oe` is 1 and `bus_dout` equals `req_wdata` only while `wr_n` is low; at all other times `bus_dout_oe` is 0.
- R5: A request with `req_kind`=2'b11 (paged access) drives `bus_addr` = {`page_reg`, `req_addr[7:0]`}, with both values sampled when the request is accepted. `req_addr[15:8]` is ignored.
- R6: A request with `req_kind`=2'b00 (internal memory) is not accepted. No strobe falls, `done` stays 0, `ready` stays 1, and `bus_addr` keeps its previous value.
- R7: An access accepted on a clock edge produces the following cycles. First, one setup cycle with the address valid and the strobes high. Next, STROBE_CYC cycles with the strobe low. Last, one hold cycle with the strobe high, the address unchanged and `done` high. `ready` returns to 1 in the cycle after that.
- R8: No more than one of `code_en_n`, `rd_n`, `wr_n` is low in any cycle.
- R9: While an access is in progress (`ready`=0), new values on `req_valid`, `req_addr` and `page_reg` have no effect on the bus.
- R10: `rdata` takes the value of `bus_din` at the end of the strobe for code and data reads. It keeps its previous value across data writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 internal, 01 code, 10 pointer data, 11 paged data |
| req_write | input | 1 | 1 = data write (ignored for code) |
| req_addr | input | 16 | Full address, or offset in bits 7:0 for paged requests |
| req_wdata | input | 8 | Write data |
| page_reg | input | 8 | Upper address byte for paged requests |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle pulse in the hold cycle |
| rdata | output | 8 | Last captured read data |
| bus_addr | output | 16 | External address bus |
| bus_dout | output | 8 | Write data toward the bus |
| bus_dout_oe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | 8 | Data returned by the external device |
| code_en_n | output | 1 | Active-low code-space enable |
| rd_n | output | 1 | Active-low data read strobe |
| wr_n | output | 1 | Active-low data write strobe |

## Verification
The assertions run on every cycle. They check that at most one strobe is low, that the idle bus is quiet, that the address is already stable when any strobe falls and stays stable until the hold cycle ends, that `done` lasts one cycle and only after a strobe, and that the data driver is on only for data-space requests. Only the bench scenarios can show that each request kind picks the correct strobe and forms the correct address. The same is true for ignoring the upper offset byte on paged requests, the data value captured on reads and held on writes, passing over internal requests, and ignoring new inputs while busy.

// File: rtl/xbus_pkg.sv
// Package: shared types for the external bus strobe sequencer.
// Assumes the request-kind encoding is fixed by the core that issues requests.
package xbus_pkg;
    typedef enum logic [1:0] {
        K_INT  = 2'b00,
        K_CODE = 2'b01,
        K_DPTR = 2'b10,
        K_PAGE = 2'b11
    } xkind_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_SETUP  = 2'b01,
        PH_STROBE = 2'b10,
        PH_HOLD   = 2'b11
    } xphase_e;
endpackage

// File: rtl/xbus_seq.sv
// Module: xbus_seq
// Steps each access through setup, strobe and hold phases.
// Assumes start is asserted only while ready is high.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int STROBE_CYC = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    output xphase_e phase,
    output logic    last_strobe,
    output logic    ready,
    output logic    done
);
    localparam int CNT_W = $clog2(STROBE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Phase register and strobe-length counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE:   if (start) phase <= PH_SETUP;
                PH_SETUP: begin
                    phase <= PH_STROBE;
                    cnt   <= '0;
                end
                PH_STROBE: begin
                    if (cnt == CNT_LAST) phase <= PH_HOLD;
                    else                 cnt   <= cnt + 1'b1;
                end
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    // Status decodes from the phase
    always_comb begin
        ready       = (phase == PH_IDLE);
        done        = (phase == PH_HOLD);
        last_strobe = (phase == PH_STROBE) && (cnt == CNT_LAST);
    end

    assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_hold_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |-> $past(last_strobe));
endmodule

// File: rtl/xbus_addr_path.sv
// Module: xbus_addr_path
// Latches the request (address, kind, write flag and write data) when it is accepted.
// Captures read data when the strobe ends.
// Assumes paged requests carry their offset in the low LOW_W bits of the address.
module xbus_addr_path
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int LOW_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  xkind_e                   kind_in,
    input  logic                     write_in,
    input  logic [ADDR_W-1:0]        addr_in,
    input  logic [ADDR_W-LOW_W-1:0]  page_in,
    input  logic [DATA_W-1:0]        wdata_in,
    input  logic                     last_strobe,
    input  xphase_e                  phase,
    input  logic [DATA_W-1:0]        din,
    output xkind_e                   kind_q,
    output logic                     write_q,
    output logic [ADDR_W-1:0]        addr_q,
    output logic [DATA_W-1:0]        wdata_q,
    output logic [DATA_W-1:0]        rdata_q
);
    logic [ADDR_W-1:0] addr_next;

    // Forms the bus address from the request kind
    always_comb begin
        if (kind_in == K_PAGE) addr_next = {page_in, addr_in[LOW_W-1:0]};
        else                   addr_next = addr_in;
    end

    // Latches the request when it is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= K_INT;
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            kind_q  <= kind_in;
            write_q <= write_in && (kind_in != K_CODE);
            addr_q  <= addr_next;
            wdata_q <= wdata_in;
        end
    end

    // Captures read data on the edge that ends the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)                       rdata_q <= '0;
        else if (last_strobe && !write_q) rdata_q <= din;
    end

    assert_addr_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(addr_q));
endmodule

// File: rtl/xbus_strobe_drv.sv
// Module: xbus_strobe_drv
// Decodes the active-low strobes and the write-data enable from the phase and the latched request.
// Assumes the request kind and write flag stay constant while an access is in progress.
module xbus_strobe_drv
    import xbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xphase_e           phase,
    input  xkind_e            kind_q,
    input  logic              write_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic              code_en_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              dout_oe,
    output logic [DATA_W-1:0] dout
);
    logic in_strobe;
    logic is_data;

    // Strobe and data-enable decode
    always_comb begin
        in_strobe = (phase == PH_STROBE);
        is_data   = (kind_q == K_DPTR) || (kind_q == K_PAGE);
        code_en_n = !(in_strobe && kind_q == K_CODE);
        rd_n      = !(in_strobe && is_data && !write_q);
        wr_n      = !(in_strobe && is_data && write_q);
        dout_oe   = in_strobe && is_data && write_q;
        dout      = wdata_q;
    end

    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!code_en_n, !rd_n, !wr_n}) <= 1);
    assert_drive_data_space_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (kind_q != K_CODE && kind_q != K_INT));
endmodule

// File: rtl/xbus_strobe_ctrl.sv
// Module: xbus_strobe_ctrl (top)
// Drives the external address and data bus with separate strobes for code space, data read and data write.
// Assumes a single outstanding request and no wait states.
module xbus_strobe_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int LOW_W      = 8,
    parameter int STROBE_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [1:0]              req_kind,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [ADDR_W-LOW_W-1:0] page_reg,
    output logic                    ready,
    output logic                    done,
    output logic [DATA_W-1:0]       rdata,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_dout,
    output logic                    bus_dout_oe,
    input  logic [DATA_W-1:0]       bus_din,
    output logic                    code_en_n,
    output logic                    rd_n,
    output logic                    wr_n
);
    xkind_e            kind_in;
    xkind_e            kind_q;
    xphase_e           phase;
    logic              start;
    logic              last_strobe;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;

    // Accept decode: an internal-memory request never starts a bus cycle
    always_comb begin
        kind_in = xkind_e'(req_kind);
        start   = req_valid && ready && (kind_in != K_INT);
    end

    xbus_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .phase(phase),
        .last_strobe(last_strobe), .ready(ready), .done(done)
    );

    xbus_addr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_W(LOW_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .start(start), .kind_in(kind_in),
        .write_in(req_write), .addr_in(req_addr), .page_in(page_reg),
        .wdata_in(req_wdata), .last_strobe(last_strobe), .phase(phase),
        .din(bus_din), .kind_q(kind_q), .write_q(write_q), .addr_q(bus_addr),
        .wdata_q(wdata_q), .rdata_q(rdata)
    );

    xbus_strobe_drv #(.DATA_W(DATA_W)) u_drv (
        .clk(clk), .rst_n(rst_n), .phase(phase), .kind_q(kind_q),
        .write_q(write_q), .wdata_q(wdata_q), .code_en_n(code_en_n),
        .rd_n(rd_n), .wr_n(wr_n), .dout_oe(bus_dout_oe), .dout(bus_dout)
    );

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (code_en_n && rd_n && wr_n && !bus_dout_oe && !done));
    assert_addr_before_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(code_en_n) || $fell(rd_n) || $fell(wr_n)) |-> $stable(bus_addr));
endmodule

// File: tb/tb_xbus_strobe_ctrl.sv
// Bench: runs a table of accesses, then directed tests for reset, internal requests and reset during an access.
module tb_xbus_strobe_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int STROBE_CYC = 2;
    localparam int NVEC = 8;
    // fields: kind[42:41] write[40] addr[39:24] page[23:16] wdata[15:8] din[7:0]
    localparam logic [42:0] VEC [NVEC] = '{
        {2'b01, 1'b0, 16'h0000, 8'h55, 8'h00, 8'hA5},
        {2'b01, 1'b1, 16'hFFFF, 8'h00, 8'h77, 8'h3C},
        {2'b10, 1'b0, 16'h8000, 8'h12, 8'h00, 8'hC3},
        {2'b10, 1'b1, 16'h1234, 8'h00, 8'h9A, 8'h11},
        {2'b11, 1'b0, 16'hAB80, 8'h40, 8'h00, 8'h5E},
        {2'b11, 1'b1, 16'hFFFF, 8'h00, 8'hE7, 8'h22},
        {2'b10, 1'b0, 16'hFFFF, 8'h7F, 8'h00, 8'h81},
        {2'b11, 1'b0, 16'h0000, 8'hFF, 8'h00, 8'h4D}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  page_reg = '0;
    logic [7:0]  bus_din = '0;
    logic        ready, done, bus_dout_oe, code_en_n, rd_n, wr_n;
    logic [7:0]  rdata, bus_dout;
    logic [15:0] bus_addr;

    int checks = 0;
    int failures = 0;
    logic [7:0]  exp_rdata = 8'h00;
    logic [15:0] last_addr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xbus_strobe_ctrl #(.STROBE_CYC(STROBE_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .page_reg(page_reg), .ready(ready), .done(done), .rdata(rdata),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe),
        .bus_din(bus_din), .code_en_n(code_en_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // strobe vector {code_en_n, rd_n, wr_n, oe}
    function automatic logic [3:0] strobes();
        return {code_en_n, rd_n, wr_n, bus_dout_oe};
    endfunction

    task automatic check_quiet(input string req);
        chk({req, " strobes/oe idle"}, 32'(strobes()), 32'b1110);
        chk({req, " done low"}, 32'(done), 0);
    endtask

    task automatic run_access(input logic [42:0] v);
        logic [1:0]  k;
        logic        w;
        logic        is_wr;
        logic [15:0] ea;
        logic [3:0]  es;
        k = v[42:41];
        w = v[40];
        is_wr = w && (k != 2'b01);
        ea = (k == 2'b11) ? {v[23:16], v[31:24]} : v[39:24];
        es = (k == 2'b01) ? 4'b0110 : (is_wr ? 4'b1101 : 4'b1010);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_write = w; req_addr = v[39:24];
        page_reg = v[23:16]; req_wdata = v[15:8]; bus_din = v[7:0];
        @(negedge clk); // setup cycle
        chk("R7 setup strobes high", 32'(strobes()), 32'b1110);
        chk("R3/R5 setup address", 32'(bus_addr), 32'(ea));
        chk("R7 busy after accept", 32'(ready), 0);
        // R9: disturb the inputs while busy
        req_addr = ~v[39:24]; page_reg = ~v[23:16];
        for (int i = 0; i < STROBE_CYC; i++) begin
            @(negedge clk);
            chk("R2/R3/R4/R8 strobe pattern", 32'(strobes()), 32'(es));
            chk("R9 address held during strobe", 32'(bus_addr), 32'(ea));
            if (is_wr) chk("R4 write data on bus", 32'(bus_dout), 32'(v[15:8]));
        end
        @(negedge clk); // hold cycle
        req_valid = 1'b0;
        if (!is_wr) exp_rdata = v[7:0];
        chk("R7 hold strobes high", 32'(strobes()), 32'b1110);
        chk("R7 done in hold", 32'(done), 1);
        chk("R7 address held in hold", 32'(bus_addr), 32'(ea));
        chk("R10 read data", 32'(rdata), 32'(exp_rdata));
        @(negedge clk);
        chk("R1 ready after access", 32'(ready), 1);
        check_quiet("R1 after access");
        last_addr = ea;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check_quiet("R1 in reset");
        chk("R1 ready in reset", 32'(ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1 after reset");
        chk("R1 ready after reset", 32'(ready), 1);
        chk("R10 rdata reset", 32'(rdata), 0);

        for (int n = 0; n < NVEC; n++) run_access(VEC[n]);

        // R6: internal request ignored
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b00; req_addr = 16'h5AA5; req_write = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_quiet("R6 internal request");
            chk("R6 ready stays", 32'(ready), 1);
            chk("R6 address unchanged", 32'(bus_addr), 32'(last_addr));
        end
        req_valid = 1'b0;

        // R1: reset in the middle of a strobe
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b10; req_write = 1'b1; req_addr = 16'h0F0F;
        req_wdata = 8'h3A;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R4 write strobe before reset", 32'(strobes()), 32'b1101);
        rst_n = 1'b0;
        @(negedge clk);
        check_quiet("R1 reset mid-access");
        chk("R1 ready after mid reset", 32'(ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1 after mid reset release");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule